// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block copies a contiguous range of bytes out of a one-time-programmable fuse array and presents them as a byte stream. A single start pulse captures a start address and a byte count. The block first makes sure the array's cell-select field points at the primary bank (value 0). It writes the field only when it holds something else, and it reads the field back after writing. It then walks the requested addresses in ascending order. For each one it issues a read request, which also clears the array's ready flag, and it polls ready once per prescaled tick.

Each returned byte leaves the block with a one-cycle valid strobe and its offset from the start address. The operation ends with a one-cycle done pulse. A busy error flag accompanies that pulse when the bank switch does not take effect or when ready fails to appear within the timeout. A timeout abandons the addresses that remain. The tick prescaler and the timeout length are parameters, so a simulation can use short values while silicon uses a one-microsecond tick and a limit of one million ticks.

Top module: `fuse_read_seq`

## Requirements
- R1: After reset, busy, done, errBusy, outValid, reqValid and selWrEn are all 0.
- R2: If selCur is already 0 (the primary bank) when a dump starts, selWrEn is never asserted during that dump.
- R3: If selCur is 1 when a dump starts, selWrEn pulses exactly once with selWrVal = 0, and only afterwards are fuse reads requested.
- R4: If selCur is still not 0 in the cycle after the bank write, the dump ends with done and errBusy = 1, and reqValid is never asserted.
- R5: Each address gets exactly one single-cycle reqValid pulse carrying that address on reqAddr. The next request is issued only after the byte for the previous address has been accepted.
- R6: Each byte accepted while fuseRdy = 1 appears on outData with a one-cycle outValid. outIdx gives its offset from the start address, counting from 0.
- R7: Requests cover startAddr through startAddr+byteCount-1 in ascending order. A count of 0 ends the dump with done and errBusy = 0, and no request or byte is produced.
- R8: fuseRdy is sampled once every TICK_DIV cycles. If TIMEOUT_TICKS consecutive samples find it low, the dump ends with errBusy = 1, and no further addresses are requested.
- R9: A start pulse that arrives while busy = 1 is ignored: the running dump keeps its address range and count.
- R10: done is a one-cycle pulse that follows the end of every dump. errBusy keeps its value from the end of a dump until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; captures startAddr and byteCount when idle |
| startAddr | input | ADDR_W | First fuse address to read |
| byteCount | input | CNT_W | Number of bytes to read |
| selCur | input | 1 | Current cell-select bank value read from the array |
| selWrEn | output | 1 | Write strobe for the cell-select field |
| selWrVal | output | 1 | Bank value written (always 0) |
| reqValid | output | 1 | Read request pulse; clears ready in the array |
| reqAddr | output | ADDR_W | Address of the current read request |
| fuseRdy | input | 1 | Ready flag from the array's control word |
| fuseData | input | 8 | Low byte of the array's control word |
| outValid | output | 1 | Output byte strobe |
| outData | output | 8 | Output byte |
| outIdx | output | CNT_W | Offset of the output byte from startAddr |
| busy | output | 1 | High from an accepted start until the dump ends |
| done | output | 1 | One-cycle end-of-dump pulse |
| errBusy | output | 1 | Busy error: bank switch failed or ready timed out |

## Verification
The checks rely on the array clearing ready in response to a request and on selCur changing only when selWrEn writes it, never on its own. The bench models the array under the same rules. Its ready flag is cleared on each request and raised after a fixed latency, except at an address chosen to stay stuck. Its bank register accepts writes unless a lock flag is set. Start pulses and input values are changed only at falling clock edges.

// File: rtl/fuse_read_seq_pkg.sv
package fuse_read_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHKBANK,
    ST_VERIFY,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH
  } seqState_t;

  typedef struct packed {
    logic load;
    logic issue;
    logic capture;
    logic waitEn;
  } seqCtl_t;

endpackage

// File: rtl/fuse_read_seq_dp.sv
module fuse_read_seq_dp
  import fuse_read_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W = 11,
  parameter int TICK_DIV = 100,
  parameter int TIMEOUT_TICKS = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic              fuseRdy,
  input  logic [7:0]        fuseData,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              outValid,
  output logic [7:0]        outData,
  output logic [CNT_W-1:0]  outIdx,
  output logic              remZero,
  output logic              tickHit,
  output logic              timeoutHit
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int TO_W  = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;

  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  idx;
  logic [PRE_W-1:0]  preCnt;
  logic [TO_W-1:0]   tickCnt;

  assign reqAddr    = curAddr;
  assign remZero    = (remain == '0);
  assign tickHit    = ctl.waitEn && (preCnt == PRE_W'(TICK_DIV - 1));
  assign timeoutHit = tickHit && !fuseRdy && (tickCnt == TO_W'(TIMEOUT_TICKS - 1));

  // Address walker and byte counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      remain  <= '0;
      idx     <= '0;
    end else if (ctl.load) begin
      curAddr <= startAddr;
      remain  <= byteCount;
      idx     <= '0;
    end else if (ctl.capture) begin
      curAddr <= curAddr + 1'b1;
      remain  <= remain - 1'b1;
      idx     <= idx + 1'b1;
    end
  end

  // Tick prescaler and timeout counter, active only while waiting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (!ctl.waitEn) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (tickHit) begin
      preCnt  <= '0;
      tickCnt <= tickCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // Output byte register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outIdx   <= '0;
    end else begin
      outValid <= ctl.capture;
      if (ctl.capture) begin
        outData <= fuseData;
        outIdx  <= idx;
      end
    end
  end

endmodule

// File: rtl/fuse_read_seq_ctrl.sv
module fuse_read_seq_ctrl
  import fuse_read_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    selCur,
  input  logic    fuseRdy,
  input  logic    remZero,
  input  logic    tickHit,
  input  logic    timeoutHit,
  output seqCtl_t ctl,
  output logic    selWrEn,
  output logic    reqValid,
  output logic    busy,
  output logic    done,
  output logic    errBusy
);

  seqState_t state, nextState;
  logic errSet;

  always_comb begin
    nextState = state;
    ctl       = '0;
    selWrEn   = 1'b0;
    reqValid  = 1'b0;
    errSet    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.load  = 1'b1;
          nextState = ST_CHKBANK;
        end
      end
      ST_CHKBANK: begin
        if (selCur == 1'b0) begin
          nextState = ST_ISSUE;
        end else begin
          selWrEn   = 1'b1;
          nextState = ST_VERIFY;
        end
      end
      ST_VERIFY: begin
        if (selCur != 1'b0) begin
          errSet    = 1'b1;
          nextState = ST_FINISH;
        end else begin
          nextState = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (remZero) begin
          nextState = ST_FINISH;
        end else begin
          reqValid  = 1'b1;
          nextState = ST_WAIT;
        end
      end
      ST_WAIT: begin
        ctl.waitEn = 1'b1;
        if (tickHit && fuseRdy) begin
          ctl.capture = 1'b1;
          nextState   = ST_ISSUE;
        end else if (timeoutHit) begin
          errSet    = 1'b1;
          nextState = ST_FINISH;
        end
      end
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      errBusy <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.load)    errBusy <= 1'b0;
      else if (errSet) errBusy <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);

endmodule

// File: rtl/fuse_read_seq.sv
module fuse_read_seq
  import fuse_read_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W = 11,
  parameter int TICK_DIV = 100,
  parameter int TIMEOUT_TICKS = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic              selCur,
  output logic              selWrEn,
  output logic              selWrVal,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  input  logic              fuseRdy,
  input  logic [7:0]        fuseData,
  output logic              outValid,
  output logic [7:0]        outData,
  output logic [CNT_W-1:0]  outIdx,
  output logic              busy,
  output logic              done,
  output logic              errBusy
);

  localparam logic PRIMARY_BANK = 1'b0;

  seqCtl_t ctl;
  logic remZero, tickHit, timeoutHit;

  assign selWrVal = PRIMARY_BANK;

  fuse_read_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .selCur(selCur), .fuseRdy(fuseRdy),
    .remZero(remZero), .tickHit(tickHit), .timeoutHit(timeoutHit), .ctl(ctl),
    .selWrEn(selWrEn), .reqValid(reqValid), .busy(busy), .done(done),
    .errBusy(errBusy)
  );

  fuse_read_seq_dp #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TICK_DIV(TICK_DIV),
    .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr),
    .byteCount(byteCount), .fuseRdy(fuseRdy), .fuseData(fuseData),
    .reqAddr(reqAddr), .outValid(outValid), .outData(outData), .outIdx(outIdx),
    .remZero(remZero), .tickHit(tickHit), .timeoutHit(timeoutHit)
  );

endmodule

// File: rtl/fuse_read_seq_chk.sv
module fuse_read_seq_chk (
  input logic clk,
  input logic rstN,
  input logic selWrEn,
  input logic selWrVal,
  input logic reqValid,
  input logic outValid,
  input logic busy,
  input logic done
);

  // R3
  bank_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    selWrEn |-> (selWrVal == 1'b0));

  // R3
  verify_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    selWrEn |=> !reqValid);

  // R5
  single_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);

  // R6
  byte_in_dump_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!busy && !reqValid && !selWrEn));

endmodule

bind fuse_read_seq fuse_read_seq_chk uChk (
  .clk(clk), .rstN(rstN), .selWrEn(selWrEn), .selWrVal(selWrVal),
  .reqValid(reqValid), .outValid(outValid), .busy(busy), .done(done)
);

// File: tb/fuse_read_seq_test.sv
module fuse_read_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int CNT_W = 11;
  localparam int TICK_DIV = 2;
  localparam int TIMEOUT_TICKS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [CNT_W-1:0] byteCount = '0;
  logic selCur, selWrEn, selWrVal, reqValid, fuseRdy;
  logic [ADDR_W-1:0] reqAddr;
  logic [7:0] fuseData, outData;
  logic outValid, busy, done, errBusy;
  logic [CNT_W-1:0] outIdx;

  int testsRun = 0;
  int testsFailed = 0;

  // array model controls
  logic bankLock = 1'b0;
  int latency = 5;
  int stuckAddr = -1;
  logic [ADDR_W-1:0] pendAddr;
  int latCnt;

  // observation
  int nBytes, nReq, nSelWr, nDone;
  logic [7:0] gotData [0:63];
  int gotIdx [0:63];
  int reqLog [0:63];
  logic orderErr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fuse_read_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TICK_DIV(TICK_DIV),
    .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .byteCount(byteCount), .selCur(selCur), .selWrEn(selWrEn),
    .selWrVal(selWrVal), .reqValid(reqValid), .reqAddr(reqAddr),
    .fuseRdy(fuseRdy), .fuseData(fuseData), .outValid(outValid),
    .outData(outData), .outIdx(outIdx), .busy(busy), .done(done),
    .errBusy(errBusy)
  );

  function automatic logic [7:0] cellByte(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction

  // bank register model
  always_ff @(posedge clk) begin
    if (selWrEn && !bankLock) selCur <= selWrVal;
  end

  // fuse array model: request clears ready, ready rises after latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fuseRdy  <= 1'b0;
      fuseData <= 8'h00;
      latCnt   <= 0;
      pendAddr <= '0;
    end else if (reqValid) begin
      fuseRdy  <= 1'b0;
      pendAddr <= reqAddr;
      latCnt   <= latency;
    end else if (latCnt > 0) begin
      latCnt <= latCnt - 1;
      if (latCnt == 1 && int'(pendAddr) != stuckAddr) begin
        fuseRdy  <= 1'b1;
        fuseData <= cellByte(int'(pendAddr));
      end
    end
  end

  // observer, sampling at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        if (nBytes < 64) begin
          gotData[nBytes] = outData;
          gotIdx[nBytes]  = int'(outIdx);
        end
        nBytes++;
      end
      if (reqValid) begin
        if (nReq < 64) reqLog[nReq] = int'(reqAddr);
        if (nBytes != nReq) orderErr = 1'b1;
        nReq++;
      end
      if (selWrEn) begin
        if (nReq != 0) orderErr = 1'b1;
        nSelWr++;
      end
      if (done) nDone++;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearObs();
    nBytes = 0; nReq = 0; nSelWr = 0; nDone = 0; orderErr = 1'b0;
  endtask

  task automatic pulseStart(input int a, input int n);
    @(negedge clk);
    startAddr = ADDR_W'(a);
    byteCount = CNT_W'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int cyc = 0;
    while (nDone == 0 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    if (nDone == 0) check(req, 0, 1, "watchdog: done never seen");
    repeat (3) @(negedge clk);
  endtask

  task automatic checkBytes(input string req, input int a, input int n);
    for (int i = 0; i < n && i < 64; i++) begin
      check(req, int'(gotData[i]), int'(cellByte(a + i)), $sformatf("byte %0d data", i));
      check(req, gotIdx[i], i, $sformatf("byte %0d index", i));
      check(req, reqLog[i], a + i, $sformatf("request %0d address", i));
    end
  endtask

  task automatic testReset();
    check("R1", int'(busy), 0, "busy after reset");
    check("R1", int'(done), 0, "done after reset");
    check("R1", int'(errBusy), 0, "errBusy after reset");
    check("R1", int'(outValid || reqValid || selWrEn), 0, "strobes after reset");
  endtask

  task automatic testBankAlreadyPrimary();
    clearObs();
    latency = 5;
    pulseStart(16, 4);
    waitDone("R2");
    check("R2", nSelWr, 0, "bank writes when already primary");
    check("R7", nReq, 4, "request count");
    check("R6", nBytes, 4, "byte count");
    check("R10", nDone, 1, "done pulses");
    check("R10", int'(errBusy), 0, "errBusy after clean dump");
    check("R5", int'(orderErr), 0, "request before previous byte");
    checkBytes("R6", 16, 4);
  endtask

  task automatic testBankSwitch();
    clearObs();
    @(negedge clk);
    selCur = 1'b1;
    pulseStart(40, 3);
    waitDone("R3");
    check("R3", nSelWr, 1, "bank writes");
    check("R3", int'(selCur), 0, "bank after switch");
    check("R3", int'(orderErr), 0, "request before bank verify");
    check("R7", nBytes, 3, "byte count after switch");
    checkBytes("R7", 40, 3);
  endtask

  task automatic testBankFail();
    clearObs();
    @(negedge clk);
    selCur = 1'b1;
    bankLock = 1'b1;
    pulseStart(8, 5);
    waitDone("R4");
    check("R4", int'(errBusy), 1, "errBusy on bank failure");
    check("R4", nReq, 0, "requests after bank failure");
    check("R4", nBytes, 0, "bytes after bank failure");
    check("R10", int'(errBusy), 1, "errBusy held after done");
    bankLock = 1'b0;
    @(negedge clk);
    selCur = 1'b0;
  endtask

  task automatic testZeroCount();
    clearObs();
    pulseStart(100, 0);
    check("R10", int'(errBusy), 0, "errBusy cleared by new start");
    waitDone("R7");
    check("R7", nDone, 1, "done on zero count");
    check("R7", nReq, 0, "requests on zero count");
    check("R7", int'(errBusy), 0, "errBusy on zero count");
  endtask

  task automatic testTimeout();
    clearObs();
    latency = 3;
    stuckAddr = 202;
    pulseStart(200, 5);
    waitDone("R8");
    check("R8", int'(errBusy), 1, "errBusy on timeout");
    check("R8", nBytes, 2, "bytes before timeout");
    check("R8", nReq, 3, "requests incl. stuck one");
    checkBytes("R8", 200, 2);
    stuckAddr = -1;
  endtask

  task automatic testSlowReady();
    // ready after 13 cycles, within 8 ticks of 2 cycles
    clearObs();
    latency = 13;
    pulseStart(300, 2);
    waitDone("R8");
    check("R8", int'(errBusy), 0, "errBusy with slow ready");
    check("R8", nBytes, 2, "bytes with slow ready");
    checkBytes("R8", 300, 2);
    latency = 5;
  endtask

  task automatic testStartWhileBusy();
    clearObs();
    latency = 6;
    pulseStart(20, 3);
    repeat (4) @(negedge clk);
    startAddr = ADDR_W'(500);
    byteCount = CNT_W'(1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone("R9");
    check("R9", nBytes, 3, "bytes with ignored start");
    check("R9", nDone, 1, "done pulses with ignored start");
    checkBytes("R9", 20, 3);
  endtask

  initial begin
    selCur = 1'b0;
    clearObs();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testBankAlreadyPrimary();
    testBankSwitch();
    testBankFail();
    testZeroCount();
    testTimeout();
    testSlowReady();
    testStartWhileBusy();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule